// File: doc/BRIEF.md
# Edge-Comparing Phase Detector with Selectable Sense

This block compares two single-bit pulse trains, a reference train and a divided feedback train, by the order of their rising edges. Both inputs are synchronous to the block clock. A rising edge on the reference sets an internal "advance" flag. A rising edge on the feedback sets a "retard" flag. Once both flags are set, a short clearing path holds them for a fixed number of cycles and then drops both together. When the two edges coincide, this gives a minimum-width pulse on both comparator outputs, which removes the dead zone around lock.

The flags drive several outputs:
- A pair of comparator lines: `cmp_p`, which idles high and goes low to request more frequency, and `cmp_r`, which idles low and goes high to request less.
- A three-state pump code on `pump_out`.
- An active-low activity flag `lock_n`.
- A test output `test_out` that mirrors one of the two inputs.

The `pol_sel` input reverses the sense of the comparator lines and the pump code. It also picks which input the test output mirrors. A second pump code, `aux_out`, copies the main one while `pump_en` is high and reads as off otherwise. These inputs and outputs are plain pins. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pfd_top`

## Requirements
- R1: Only a low-to-high transition of `ref_in` or `fb_in` arms a flag; holding an input high for many cycles arms it once.
- R2: With `pol_sel`=1 and the reference edge k cycles ahead of the feedback edge, `cmp_p` is low for k+DB_CYCLES cycles, `cmp_r` is high for DB_CYCLES cycles, and `pump_out` reads source (2'b01) for k cycles.
- R3: With `pol_sel`=1 and the feedback edge k cycles ahead, `cmp_r` is high for k+DB_CYCLES cycles, `cmp_p` is low for DB_CYCLES cycles, and `pump_out` reads sink (2'b10) for k cycles.
- R4: Coincident edges give a pulse of exactly DB_CYCLES cycles on both comparator lines, and `pump_out` stays off (2'b00).
- R5: With `pol_sel`=0, the roles are swapped. The reference-ahead case drives `cmp_r` high for k+DB_CYCLES cycles and `pump_out` to sink. The feedback-ahead case drives `cmp_p` low for k+DB_CYCLES cycles and `pump_out` to source.
- R6: `lock_n` is low exactly while either flag is set, and high otherwise.
- R7: `test_out` equals `ref_in` when `pol_sel`=1 and `fb_in` when `pol_sel`=0, in the same cycle.
- R8: `aux_out` equals `pump_out` while `pump_en`=1 and is 2'b00 while `pump_en`=0; `pump_out` does not depend on `pump_en`.
- R9: A rising edge that arrives in the cycle in which both flags are being cleared re-arms its own flag and is not lost.
- R10: While reset is held and right after it, `cmp_p`=1, `cmp_r`=0, `pump_out`=2'b00, `aux_out`=2'b00 and `lock_n`=1.
- R11: A second reference edge that arrives before the feedback edge is absorbed. The advance flag stays set without a gap until the feedback edge, which gives a range of one full input period each way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| pol_sel | input | 1 | Sense select: 1 normal, 0 reversed; also steers test_out |
| pump_en | input | 1 | Enables the auxiliary pump code |
| cmp_r | output | 1 | Comparator line, idles low, high asks for less frequency (normal sense) |
| cmp_p | output | 1 | Comparator line, idles high, low asks for more frequency (normal sense) |
| pump_out | output | 2 | Pump code: 00 off, 01 source, 10 sink |
| aux_out | output | 2 | Auxiliary pump code, same encoding, 00 when disabled |
| lock_n | output | 1 | Low while a phase or frequency difference is being reported |
| test_out | output | 1 | Mirror of ref_in or fb_in |

## Verification
An input edge is registered by the edge detector and seen at the first clock after it is driven. The flag outputs therefore move one cycle after the stimulus, and a pulse lasts the edge separation plus DB_CYCLES. The test mux and the auxiliary gating are combinational and are due within the same cycle. The bench drives inputs on the falling edge and samples once per falling edge, before it drives. It counts the cycles each output spends active over a window that ends idle, so the counts compare directly to the widths required above, whatever cycle the pulse starts in.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PUMP_OFF = 2'b00,
    PUMP_SRC = 2'b01,
    PUMP_SNK = 2'b10
  } pump_e;

  localparam int unsigned NCH   = 2;
  localparam int unsigned CH_RF = 0;
  localparam int unsigned CH_FB = 1;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= sig[g];
    end
    assign rise[g] = sig[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int unsigned DB_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_rise,
  input  logic ret_rise,
  output logic adv_q,
  output logic ret_q
);
  localparam int unsigned CW = (DB_CYCLES < 2) ? 1 : $clog2(DB_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

  logic [CW-1:0] hold_cnt;
  logic          both, clr;
  logic          adv_d, ret_d;

  assign both = adv_q & ret_q;
  assign clr  = both && (hold_cnt == LAST);

  always_comb begin
    adv_d = clr ? adv_rise : (adv_q | adv_rise);
    ret_d = clr ? ret_rise : (ret_q | ret_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q    <= 1'b0;
      ret_q    <= 1'b0;
      hold_cnt <= '0;
    end else begin
      adv_q    <= adv_d;
      ret_q    <= ret_d;
      hold_cnt <= (both && !clr) ? hold_cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/pfd_outmap.sv
module pfd_outmap
  import pfd_pkg::*;
(
  input  logic       adv_q,
  input  logic       ret_q,
  input  logic       pol_sel,
  input  logic       pump_en,
  input  logic       ref_in,
  input  logic       fb_in,
  output logic       cmp_r,
  output logic       cmp_p,
  output logic [1:0] pump_out,
  output logic [1:0] aux_out,
  output logic       lock_n,
  output logic       test_out
);
  logic  inc_req, dec_req;
  pump_e code;

  always_comb begin
    inc_req = pol_sel ? adv_q : ret_q;
    dec_req = pol_sel ? ret_q : adv_q;
    if (inc_req && !dec_req)      code = PUMP_SRC;
    else if (dec_req && !inc_req) code = PUMP_SNK;
    else                          code = PUMP_OFF;
  end

  assign cmp_p    = ~inc_req;
  assign cmp_r    = dec_req;
  assign pump_out = code;
  assign aux_out  = pump_en ? code : PUMP_OFF;
  assign lock_n   = ~(adv_q | ret_q);
  assign test_out = pol_sel ? ref_in : fb_in;
endmodule

// File: rtl/pfd_top.sv
module pfd_top
  import pfd_pkg::*;
#(
  parameter int unsigned DB_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic       pol_sel,
  input  logic       pump_en,
  output logic       cmp_r,
  output logic       cmp_p,
  output logic [1:0] pump_out,
  output logic [1:0] aux_out,
  output logic       lock_n,
  output logic       test_out
);
  logic [NCH-1:0] rise;
  logic           adv_q, ret_q;

  pfd_edge #(.N(NCH)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  ({fb_in, ref_in}),
    .rise (rise)
  );

  pfd_core #(.DB_CYCLES(DB_CYCLES)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_rise(rise[CH_RF]),
    .ret_rise(rise[CH_FB]),
    .adv_q   (adv_q),
    .ret_q   (ret_q)
  );

  pfd_outmap u_map (
    .adv_q   (adv_q),
    .ret_q   (ret_q),
    .pol_sel (pol_sel),
    .pump_en (pump_en),
    .ref_in  (ref_in),
    .fb_in   (fb_in),
    .cmp_r   (cmp_r),
    .cmp_p   (cmp_p),
    .pump_out(pump_out),
    .aux_out (aux_out),
    .lock_n  (lock_n),
    .test_out(test_out)
  );
endmodule

// File: rtl/pfd_chk.sv
module pfd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_in,
  input logic       fb_in,
  input logic       pol_sel,
  input logic       pump_en,
  input logic       cmp_r,
  input logic       cmp_p,
  input logic [1:0] pump_out,
  input logic [1:0] aux_out,
  input logic       lock_n,
  input logic       test_out
);
  assert_lock_vs_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n == !(cmp_r || !cmp_p));

  assert_pump_implies_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_out != 2'b00) |-> !lock_n);

  assert_ref_edge_reported_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_in) |=> !lock_n);

  assert_fb_edge_reported_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_in) |=> !lock_n);

  assert_aux_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_en |-> (aux_out == 2'b00));

  assert_aux_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pump_en |-> (aux_out == pump_out));

  assert_test_mux_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_out == (pol_sel ? ref_in : fb_in));

  assert_pump_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pump_out != 2'b11);
endmodule

bind pfd_top pfd_chk u_chk (.*);

// File: tb/sim_pfd_top.sv
module sim_pfd_top;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0, fb_in = 1'b0, pol_sel = 1'b1, pump_en = 1'b1;
  logic       cmp_r, cmp_p, lock_n, test_out;
  logic [1:0] pump_out, aux_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_top #(.DB_CYCLES(DB)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pol_sel(pol_sel), .pump_en(pump_en), .cmp_r(cmp_r), .cmp_p(cmp_p),
    .pump_out(pump_out), .aux_out(aux_out), .lock_n(lock_n), .test_out(test_out)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Drives one reference train (edge at ra, high for hold+1 cycles) and one
  // feedback pulse (edge at fa), counts the cycles each output spends active.
  task automatic run_pair(input string tag, input int ra, input int fa,
                          input int hold, input logic fc, input logic le);
    int n_plo = 0, n_rhi = 0, n_src = 0, n_snk = 0, n_lk = 0, n_aux = 0, n_mux = 0;
    int w = ((ra > fa) ? ra : fa) + hold + DB + 6;
    int d, e_adv, e_ret, e_ao, e_ro;
    pol_sel = fc;
    pump_en = le;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (!cmp_p) n_plo++;
      if (cmp_r) n_rhi++;
      if (pump_out == 2'b01) n_src++;
      if (pump_out == 2'b10) n_snk++;
      if (!lock_n) n_lk++;
      if (aux_out != (le ? pump_out : 2'b00)) n_aux++;
      ref_in = (i >= ra) && (i <= ra + hold);
      fb_in  = (i == fa) || (i == fa + 1);
      #1;
      if (test_out != (fc ? ref_in : fb_in)) n_mux++;
    end
    d     = (ra > fa) ? ra - fa : fa - ra;
    e_adv = (ra <= fa) ? d + DB : DB;
    e_ret = (fa <= ra) ? d + DB : DB;
    e_ao  = (ra < fa) ? d : 0;
    e_ro  = (fa < ra) ? d : 0;
    if (fc) begin
      check({tag, " cmp_p low cycles"}, n_plo, e_adv);
      check({tag, " cmp_r high cycles"}, n_rhi, e_ret);
      check({tag, " source cycles"}, n_src, e_ao);
      check({tag, " sink cycles"}, n_snk, e_ro);
    end else begin
      check({tag, " R5 cmp_r high cycles"}, n_rhi, e_adv);
      check({tag, " R5 cmp_p low cycles"}, n_plo, e_ret);
      check({tag, " R5 sink cycles"}, n_snk, e_ao);
      check({tag, " R5 source cycles"}, n_src, e_ro);
    end
    check({tag, " R6 lock_n low cycles"}, n_lk, d + DB);
    check({tag, " R8 aux mismatches"}, n_aux, 0);
    check({tag, " R7 test_out mismatches"}, n_mux, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 cmp_p in reset", cmp_p, 1);
    check("R10 cmp_r in reset", cmp_r, 0);
    check("R10 pump in reset", pump_out, 0);
    check("R10 aux in reset", aux_out, 0);
    check("R10 lock_n in reset", lock_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 lock_n after reset", lock_n, 1);
    check("R10 cmp_p after reset", cmp_p, 1);
  endtask

  task automatic t_clear_edge;
    pol_sel = 1'b1;
    pump_en = 1'b1;
    for (int i = 0; i < 2 + DB + 2; i++) begin
      @(negedge clk);
      ref_in = (i <= 1) || (i == 2 + DB);
      fb_in  = (i == 2) || (i == 3);
    end
    check("R9 cmp_p low after clear", cmp_p, 0);
    check("R9 cmp_r low after clear", cmp_r, 0);
    check("R9 lock_n low after clear", lock_n, 0);
    check("R9 pump source after clear", pump_out, 1);
    for (int i = 0; i < DB + 8; i++) begin
      @(negedge clk);
      ref_in = 1'b0;
      fb_in  = (i == 0) || (i == 1);
    end
    check("R9 idle after final feedback edge", lock_n, 1);
  endtask

  task automatic t_double_ref;
    int n_plo = 0, n_src = 0, gaps = 0;
    logic seen = 1'b0;
    pol_sel = 1'b1;
    for (int i = 0; i < 8 + DB + 6; i++) begin
      @(negedge clk);
      if (!cmp_p) n_plo++;
      if (pump_out == 2'b01) n_src++;
      if (seen && cmp_p && i <= 8) gaps++;
      if (!cmp_p) seen = 1'b1;
      ref_in = (i == 0) || (i == 1) || (i == 4) || (i == 5);
      fb_in  = (i == 8) || (i == 9);
    end
    check("R11 cmp_p low cycles", n_plo, 8 + DB);
    check("R11 source cycles", n_src, 8);
    check("R11 gaps before feedback", gaps, 0);
  endtask

  task automatic t_pump_en_indep;
    int n_src = 0;
    pol_sel = 1'b1;
    pump_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pump_out == 2'b01) n_src++;
      ref_in = (i == 0) || (i == 1);
      fb_in  = (i == 4) || (i == 5);
    end
    check("R8 pump_out unaffected by pump_en", n_src, 4);
    pump_en = 1'b1;
  endtask

  initial begin
    t_reset();
    run_pair("R2 ref ahead 3", 0, 3, 1, 1'b1, 1'b1);
    run_pair("R2 ref ahead 7", 1, 8, 1, 1'b1, 1'b0);
    run_pair("R3 fb ahead 4", 4, 0, 1, 1'b1, 1'b1);
    run_pair("R4 coincident", 2, 2, 1, 1'b1, 1'b1);
    run_pair("R4 coincident rev", 2, 2, 1, 1'b0, 1'b0);
    run_pair("ref ahead 5 rev", 0, 5, 1, 1'b0, 1'b1);
    run_pair("fb ahead 2 rev", 2, 0, 1, 1'b0, 1'b1);
    run_pair("R1 ref held", 0, 3, 14, 1'b1, 1'b1);
    t_clear_edge();
    t_double_ref();
    t_pump_en_indep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule